// File: doc/BRIEF.md
# Compare Match Timer Channel

A single timer channel with a small memory-mapped register file: a control/status word, an up-counter and a compare value. The counter advances on a divided version of a slow reference tick, with the divider picked by a three-bit code in the control word. It advances only while an externally supplied start bit is high. When the count equals the compare value, the channel raises a match flag. In periodic mode the counter also returns to zero, so one period lasts compare value plus one divided ticks.

Software reads and writes the three registers through a plain address/write-enable/data bus. It clears the sticky match and overflow flags with a read-modify-write that writes zero into them. A counter write takes effect only after two slow reference ticks. Until then, reads still return the old count. The interrupt line follows the match flag whenever the interrupt-output enable is set and the routing field selects the interrupt path.

Top module: `cmtimer_chan`

## Requirements
- R1: After reset the control word and the counter read as zero, the compare register reads as all ones, and irq_o is low.
- R2: Register word index 0 selects control/status, 1 the counter and 2 the compare value. The byte address is the index times four. Index 3 reads as zero.
- R3: Control fields are bit 15 match flag, bit 14 overflow flag, bit 8 periodic mode, bit 7 interrupt-output enable, bits 5:4 routing (0 none, 1 DMA, 2 interrupt) and bits 2:0 clock select. All other bits read as zero, and writing ones to them has no effect.
- R4: Clock-select code 7 counts every slow tick, 4 every 8th, 5 every 32nd and 6 every 128th. Codes 0 to 3 do not count.
- R5: In periodic mode, a divided tick that finds the count equal to the compare value returns the counter to zero and sets the match flag, giving a period of compare plus one ticks.
- R6: With periodic mode clear, a match sets the match flag and the counter keeps counting past the compare value.
- R7: A divided tick that finds the counter at all ones wraps it to zero and sets the overflow flag.
- R8: A control write with 0 in bit 15 or 14 clears that flag, and a write with 1 leaves it unchanged.
- R9: A counter write is not visible on reads or in counting until the second slow tick after the write. At that tick the written value is loaded.
- R10: The counter advances only while start_i is high. Lowering start_i freezes the count without clearing it.
- R11: irq_o is high exactly while the match flag is set, bit 7 is set and bits 5:4 equal 2. Writing zero to the control word drops irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start_i | input | 1 | channel start bit from the shared start/stop register |
| slow_tick_i | input | 1 | one-cycle pulse per slow reference clock period |
| reg_addr_i | input | ADDR_W | byte address of the register access |
| reg_we_i | input | 1 | write strobe |
| reg_wdata_i | input | BUS_W | write data |
| reg_rdata_o | output | BUS_W | read data for the addressed register (combinational) |
| irq_o | output | 1 | interrupt request |

## Verification
A control or compare write shows on the read port after the single clock edge that samples the strobe. A counter write shows only after the edge that samples the second following slow tick. A divided tick changes the count and flags at the edge that samples it, and irq_o follows the stored flag in the same cycle. The bench therefore drives and samples only on falling edges. Every tick is a one-cycle pulse, so each read lands one known edge after the event that caused it. Expected counts come from the divide ratio and the compare value alone.

// File: rtl/cmtimer_pkg.sv
package cmtimer_pkg;

  localparam int CTL_W = 16;
  localparam int PRE_W = 7;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_DMA  = 2'd1,
    ROUTE_IRQ  = 2'd2,
    ROUTE_RSV  = 2'd3
  } route_e;

  typedef struct packed {
    logic       cmf;
    logic       ovf;
    logic       per;
    logic       ien;
    route_e     route;
    logic [2:0] cks;
  } ctl_t;

  // Place the control fields at their architectural bit positions.
  function automatic logic [CTL_W-1:0] ctl_pack(ctl_t c);
    logic [CTL_W-1:0] w;
    w       = '0;
    w[15]   = c.cmf;
    w[14]   = c.ovf;
    w[8]    = c.per;
    w[7]    = c.ien;
    w[5:4]  = c.route;
    w[2:0]  = c.cks;
    return w;
  endfunction

  // Terminal value of the prescaler for a clock-select code.
  function automatic logic [PRE_W-1:0] pre_limit(logic [2:0] cks);
    case (cks)
      3'd4:    return PRE_W'(7);
      3'd5:    return PRE_W'(31);
      3'd6:    return PRE_W'(127);
      default: return PRE_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/cmtimer_presc.sv
module cmtimer_presc
  import cmtimer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick_i,
  input  logic       run_i,
  input  logic [2:0] cks_i,
  output logic       cnt_tick_o
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             lim_hit;

  always_comb begin
    lim_hit = (pre_q >= pre_limit(cks_i));
    pre_d   = pre_q;
    if (!run_i) begin
      pre_d = '0;
    end else if (slow_tick_i) begin
      pre_d = lim_hit ? '0 : pre_q + PRE_W'(1);
    end
    cnt_tick_o = run_i & slow_tick_i & lim_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/cmtimer_count.sv
module cmtimer_count #(
  parameter int CNT_W    = 32,
  parameter int WR_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick_i,
  input  logic             cnt_tick_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             match_evt_o,
  output logic             ovf_evt_o
);

  localparam int PW = $clog2(WR_DELAY + 1);

  logic [PW-1:0]    pend_q, pend_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             busy, load, inc, at_cmp;

  always_comb begin
    busy   = (pend_q != '0);
    load   = slow_tick_i && (pend_q == PW'(1)) && !wr_en_i;
    inc    = cnt_tick_i && !busy && !wr_en_i;
    at_cmp = (count_q == cmp_i);

    match_evt_o = inc && at_cmp;
    ovf_evt_o   = inc && (&count_q);

    hold_d = wr_en_i ? wr_data_i : hold_q;

    pend_d = pend_q;
    if (wr_en_i)                  pend_d = PW'(WR_DELAY);
    else if (busy && slow_tick_i) pend_d = pend_q - PW'(1);

    count_d = count_q;
    if (load)                     count_d = hold_q;
    else if (inc)                 count_d = (periodic_i && at_cmp) ? '0 : count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      hold_q  <= '0;
      count_q <= '0;
    end else begin
      pend_q  <= pend_d;
      hold_q  <= hold_d;
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick_i && !wr_en_i && pend_q == '0) |=> $stable(count_q)); // R10

  AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick_i && !wr_en_i && pend_q == '0 && periodic_i && count_q == cmp_i) |=> (count_q == '0)); // R5

  AST_WRITE_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> $stable(count_q)); // R9

endmodule

// File: rtl/cmtimer_ctrl.sv
module cmtimer_ctrl
  import cmtimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             match_evt_i,
  input  logic             ovf_evt_i,
  output ctl_t             ctl_o,
  output logic             irq_o
);

  ctl_t ctl_q, ctl_d;
  logic unused_wbits;

  assign unused_wbits = ^{wdata_i[13:9], wdata_i[6], wdata_i[3]};

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en_i) begin
      ctl_d.per   = wdata_i[8];
      ctl_d.ien   = wdata_i[7];
      ctl_d.route = route_e'(wdata_i[5:4]);
      ctl_d.cks   = wdata_i[2:0];
      ctl_d.cmf   = ctl_q.cmf & wdata_i[15];
      ctl_d.ovf   = ctl_q.ovf & wdata_i[14];
    end
    // A hardware event wins over a software clear in the same cycle.
    if (match_evt_i) ctl_d.cmf = 1'b1;
    if (ovf_evt_i)   ctl_d.ovf = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
  assign irq_o = ctl_q.cmf & ctl_q.ien & (ctl_q.route == ROUTE_IRQ);

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.cmf && !wr_en_i) |=> ctl_q.cmf); // R8

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_i |=> ctl_q.ovf); // R7

  AST_IRQ_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wdata_i == '0 && !match_evt_i) |=> !irq_o); // R11

endmodule

// File: rtl/cmtimer_chan.sv
module cmtimer_chan
  import cmtimer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 4,
  parameter int WR_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              slow_tick_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  output logic              irq_o
);

  localparam int LSB   = $clog2(BUS_W / 8);
  localparam int IDX_W = ADDR_W - LSB;

  logic [IDX_W-1:0] idx;
  logic             we_ctl, we_cnt, we_cmp;
  logic [CNT_W-1:0] cmp_q, cmp_d, count;
  logic [BUS_W-1:0] cnt_word, cmp_word;
  logic             cnt_tick, match_evt, ovf_evt, run;
  ctl_t             ctl;
  logic             unused_addr;

  assign idx         = reg_addr_i[ADDR_W-1:LSB];
  assign unused_addr = ^reg_addr_i[LSB-1:0];
  assign we_ctl      = reg_we_i && (idx == IDX_W'(0));
  assign we_cnt      = reg_we_i && (idx == IDX_W'(1));
  assign we_cmp      = reg_we_i && (idx == IDX_W'(2));
  assign run         = start_i && ctl.cks[2];

  always_comb begin
    cmp_d = cmp_q;
    if (we_cmp) cmp_d = reg_wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '1;
    else        cmp_q <= cmp_d;
  end

  cmtimer_presc u_presc (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_tick_i (slow_tick_i),
    .run_i       (run),
    .cks_i       (ctl.cks),
    .cnt_tick_o  (cnt_tick)
  );

  cmtimer_count #(.CNT_W(CNT_W), .WR_DELAY(WR_DELAY)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_tick_i (slow_tick_i),
    .cnt_tick_i  (cnt_tick),
    .periodic_i  (ctl.per),
    .cmp_i       (cmp_q),
    .wr_en_i     (we_cnt),
    .wr_data_i   (reg_wdata_i[CNT_W-1:0]),
    .count_o     (count),
    .match_evt_o (match_evt),
    .ovf_evt_o   (ovf_evt)
  );

  cmtimer_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (we_ctl),
    .wdata_i     (reg_wdata_i[CTL_W-1:0]),
    .match_evt_i (match_evt),
    .ovf_evt_i   (ovf_evt),
    .ctl_o       (ctl),
    .irq_o       (irq_o)
  );

  generate
    if (CNT_W == BUS_W) begin : g_full
      assign cnt_word = count;
      assign cmp_word = cmp_q;
    end else begin : g_ext
      assign cnt_word = {{(BUS_W - CNT_W){1'b0}}, count};
      assign cmp_word = {{(BUS_W - CNT_W){1'b0}}, cmp_q};
    end
  endgenerate

  always_comb begin
    unique case (idx)
      IDX_W'(0): reg_rdata_o = BUS_W'(ctl_pack(ctl));
      IDX_W'(1): reg_rdata_o = cnt_word;
      IDX_W'(2): reg_rdata_o = cmp_word;
      default:   reg_rdata_o = '0;
    endcase
  end

  AST_STOPPED_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |-> !cnt_tick); // R10

endmodule

// File: tb/cmtimer_chan_tb_top.sv
module cmtimer_chan_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        stick;
  logic [3:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmtimer_chan dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .slow_tick_i (stick),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic        per;
    logic [31:0] cor;
    logic [15:0] ticks;
    logic [31:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{3'd7, 1'b1, 32'd9,   16'd5,   32'd5, 1'b0},
    '{3'd7, 1'b1, 32'd9,   16'd10,  32'd0, 1'b1},
    '{3'd7, 1'b1, 32'd9,   16'd23,  32'd3, 1'b1},
    '{3'd4, 1'b1, 32'd100, 16'd40,  32'd5, 1'b0},
    '{3'd5, 1'b1, 32'd100, 16'd100, 32'd3, 1'b0},
    '{3'd6, 1'b1, 32'd100, 16'd300, 32'd2, 1'b0},
    '{3'd4, 1'b1, 32'd2,   16'd33,  32'd1, 1'b1},
    '{3'd7, 1'b0, 32'd3,   16'd6,   32'd6, 1'b1},
    '{3'd2, 1'b1, 32'd9,   16'd20,  32'd0, 1'b0},
    '{3'd7, 1'b1, 32'd0,   16'd4,   32'd0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    addr  = 4'(idx * 4);
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    addr = 4'(idx * 4);
    #1;
    d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stick = 1'b1;
      @(negedge clk);
      stick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0;
    start = 1'b0;
    stick = 1'b0;
    addr  = '0;
    we    = 1'b0;
    wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: reset values through the register map
    rd(0, r); check("R1 ctrl reset", r, 32'h0);
    rd(1, r); check("R1 counter reset", r, 32'h0);
    rd(2, r); check("R1 R2 compare reset", r, 32'hFFFF_FFFF);
    rd(3, r); check("R2 unmapped index", r, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);

    // R3: only the defined fields hold written ones
    wr(0, 32'h0000_FFFF);
    rd(0, r); check("R3 field mask", r, 32'h0000_01B7);

    // R9: counter write deferred by two slow ticks
    wr(0, 32'h0000_0007);
    wr(1, 32'h0000_0055);
    rd(1, r); check("R9 no immediate effect", r, 32'h0);
    tick(1);
    rd(1, r); check("R9 hidden after one tick", r, 32'h0);
    tick(1);
    rd(1, r); check("R9 visible after two ticks", r, 32'h55);

    // R4 R5 R6 R10: vector table
    for (int v = 0; v < NVEC; v++) begin
      start = 1'b0;
      wr(0, {23'b0, VECS[v].per, 5'b0, VECS[v].sel});
      wr(2, VECS[v].cor);
      wr(1, 32'h0);
      tick(2);
      @(negedge clk);
      start = 1'b1;
      tick(int'(VECS[v].ticks));
      @(negedge clk);
      start = 1'b0;
      rd(1, r); check($sformatf("R4 R5 R6 R10 vector %0d count", v), r, VECS[v].exp_cnt);
      rd(0, r); check($sformatf("R5 R6 vector %0d match flag", v), {31'b0, r[15]}, {31'b0, VECS[v].exp_flag});
    end

    // R7: all-ones wrap sets overflow
    wr(0, 32'h0000_0007);
    wr(2, 32'h0000_0010);
    wr(1, 32'hFFFF_FFFE);
    tick(2);
    @(negedge clk); start = 1'b1;
    tick(1);
    rd(1, r); check("R7 count at max", r, 32'hFFFF_FFFF);
    rd(0, r); check("R7 no overflow yet", {31'b0, r[14]}, 32'h0);
    tick(1);
    @(negedge clk); start = 1'b0;
    rd(1, r); check("R7 wrapped to zero", r, 32'h0);
    rd(0, r); check("R7 overflow flag", {31'b0, r[14]}, 32'h1);

    // R8: writing one keeps, writing zero clears
    wr(0, 32'h0000_4007);
    rd(0, r); check("R8 one keeps overflow", r, 32'h0000_4007);
    wr(0, 32'h0000_0007);
    rd(0, r); check("R8 zero clears overflow", r, 32'h0000_0007);

    // R10: stop freezes, restart continues
    @(negedge clk); start = 1'b1;
    tick(3);
    @(negedge clk); start = 1'b0;
    tick(5);
    rd(1, r); check("R10 frozen while stopped", r, 32'h3);
    @(negedge clk); start = 1'b1;
    tick(1);
    @(negedge clk); start = 1'b0;
    rd(1, r); check("R10 resumes from frozen value", r, 32'h4);

    // R11: interrupt gating
    wr(0, 32'h0000_01A7);
    wr(2, 32'h0000_0001);
    wr(1, 32'h0);
    tick(2);
    #1; check("R11 irq low before match", {31'b0, irq}, 32'h0);
    @(negedge clk); start = 1'b1;
    tick(2);
    @(negedge clk); start = 1'b0;
    #1; check("R11 irq on match", {31'b0, irq}, 32'h1);
    wr(0, 32'h0000_8197);
    #1; check("R11 irq off with DMA routing", {31'b0, irq}, 32'h0);
    rd(0, r); check("R8 flag kept by writing one", r, 32'h0000_8197);
    wr(0, 32'h0000_81A7);
    #1; check("R11 irq back with interrupt routing", {31'b0, irq}, 32'h1);
    wr(0, 32'h0);
    #1; check("R11 irq off after zero write", {31'b0, irq}, 32'h0);
    rd(0, r); check("R8 R11 ctrl cleared", r, 32'h0);

    finish_run();
  end

endmodule